// File: doc/BRIEF.md
# Programmable Interval Timer with PWM Output

This block is a 16-bit counter that advances on prescaled ticks of an external tick input, counting up or down. It runs in one of two ranges: interval mode, where it cycles between 0 and a programmed limit, and overflow mode, where it cycles over the whole 16-bit range. Three compare values are checked against each new count. The first compare value also drives a waveform pin, so the limit sets the PWM period and that compare value sets the duty.

Each cause (interval wrap, overflow wrap, and the three compares) is latched in a status register. Reading that register returns the pending causes and clears them in the same access. A per-cause enable mask is combined with the status bits to form the interrupt line.

A three-state machine controls the counter. ST_HALT holds the count. ST_RUN lets it step. ST_LOAD is a single cycle that reloads the starting value. The transitions are:
- HALT→RUN when the halt bit is cleared.
- RUN→HALT when the halt bit is set.
- Any state→LOAD when the restart bit is written.
- LOAD→RUN or LOAD→HALT, chosen by the halt bit.

Top module: `pwm_interval_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0x0001 (halted), the count (address 7) and status (address 6) read 0, and `wave_o` and `irq_o` are low.
- R2: Control bit 6 enables the prescaler and bits 11:8 hold N. The counter steps once every 2^(N+1) ticks, so N=0 divides by 2 and N=1 divides by 4. When bit 6 is 0, every tick steps the counter.
- R3: When control bit 2 is 0 each step adds one. When it is 1 each step subtracts one.
- R4: Control bit 3 selects the range. With bit 3 at 0 (interval mode), counting up wraps from the limit (address 1) to 0, and counting down wraps from 0 to the limit. Each wrap sets status bit 0.
- R5: With control bit 3 at 1 (overflow mode), the counter wraps between 0xFFFF and 0 in either direction, and each wrap sets status bit 1.
- R6: With control bit 4 set, a step that lands the count on compare value k (addresses 2, 3, 4 for k = 0, 1, 2) sets status bit 2+k.
- R7: With control bit 5 set, `wave_o` inverts when a step lands on compare value 0 and returns to low on a wrap. Compares 1 and 2 never move it. When control bit 5 is clear, `wave_o` is held low.
- R8: While control bit 0 (halt) is set, ticks do not change the count. Writing the halt bit stores the other control bits exactly as written.
- R9: Writing control bit 1 reloads the count one cycle later. The reload value is 0 when counting up, and the limit (interval mode) or 0xFFFF (overflow mode) when counting down. The reload also clears `wave_o`, and bit 1 reads back as 0 afterwards.
- R10: A read of address 6 returns the pending status bits and clears them. `irq_o` is high while any status bit is set together with its enable bit in address 5 (same bit order).
- R11: Without ticks, the count holds its value indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counting clock enable, one tick per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read side effects) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| wave_o | output | 1 | PWM waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every cycle. They cover four things: the prescaler never steps on two ticks in a row while division is on, the count never changes without a step or a reload, the wrap returns the count to 0 at the top of an upward count in both modes, and a status read with no new event empties the status register. The bench scenarios are needed for the values the properties cannot predict on their own. These are the exact division ratios, the reload value in each direction and mode, the waveform level across compare hits and wraps, the status codes that accumulate over whole count sequences, and the masking of the interrupt line.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int NMATCH = 3;
    localparam int NSTAT  = 2 + NMATCH;
    localparam int PSEL_W = 4;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_LIMIT  = 3'd1;
    localparam logic [2:0] A_MATCH0 = 3'd2;
    localparam logic [2:0] A_MATCH1 = 3'd3;
    localparam logic [2:0] A_MATCH2 = 3'd4;
    localparam logic [2:0] A_IEN    = 3'd5;
    localparam logic [2:0] A_STAT   = 3'd6;
    localparam logic [2:0] A_COUNT  = 3'd7;

    typedef struct packed {
        logic [3:0]        rsv_hi;
        logic [PSEL_W-1:0] pre_sel;
        logic              rsv_lo;
        logic              pre_en;
        logic              wave_en;
        logic              match_en;
        logic              ovf_mode;
        logic              down;
        logic              restart;
        logic              halt;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(16'h0001);

    typedef struct packed {
        logic [NMATCH-1:0] match;
        logic              ovf;
        logic              intv;
    } evt_t;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOAD = 2'd2
    } run_state_e;

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            tick_i,
    input  logic            en_i,
    input  logic [SELW-1:0] sel_i,
    output logic            step_o
);
    localparam int PCW = 1 << SELW;

    logic [PCW-1:0] cnt_q;
    logic [PCW-1:0] lim;

    assign lim    = {PCW{1'b1}} >> (SELW'(PCW - 1) - sel_i);
    assign step_o = tick_i && (!en_i || (cnt_q >= lim));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && en_i) begin
            cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: with division on, two consecutive steps are impossible
    p_prescale_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_o) |=> (!step_o || !en_i));

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        halt_i,
    input  logic                        restart_i,
    input  logic                        down_i,
    input  logic                        ovf_mode_i,
    input  logic                        match_en_i,
    input  logic                        wave_en_i,
    input  logic [CW-1:0]               limit_i,
    input  logic [NMATCH-1:0][CW-1:0]   match_i,
    input  logic                        step_i,
    output logic                        run_o,
    output logic                        load_o,
    output logic [CW-1:0]               count_o,
    output logic                        wave_o,
    output evt_t                        evt_o
);
    run_state_e state_q, state_d;
    logic [CW-1:0] count_q, nxt, top_val;
    logic wrap, adv, wave_q;
    logic [NMATCH-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_HALT: if (!halt_i) state_d = ST_RUN;
                ST_RUN:  if (halt_i)  state_d = ST_HALT;
                ST_LOAD: state_d = halt_i ? ST_HALT : ST_RUN;
                default: state_d = ST_HALT;
            endcase
        end
    end

    assign run_o   = (state_q == ST_RUN) && !halt_i;
    assign load_o  = (state_q == ST_LOAD);
    assign adv     = run_o && step_i;
    assign top_val = ovf_mode_i ? '1 : limit_i;

    always_comb begin
        if (down_i) begin
            wrap = (count_q == '0);
            nxt  = wrap ? top_val : count_q - 1'b1;
        end else begin
            wrap = (count_q >= top_val);
            nxt  = wrap ? '0 : count_q + 1'b1;
        end
    end

    for (genvar k = 0; k < NMATCH; k++) begin : g_cmp
        assign hit[k] = adv && match_en_i && (nxt == match_i[k]);
    end

    assign evt_o = {hit, adv && wrap && ovf_mode_i, adv && wrap && !ovf_mode_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            wave_q  <= 1'b0;
        end else if (state_q == ST_LOAD) begin
            count_q <= down_i ? top_val : '0;
            wave_q  <= 1'b0;
        end else begin
            if (adv) count_q <= nxt;
            if (!wave_en_i) begin
                wave_q <= 1'b0;
            end else if (adv) begin
                if (wrap)                      wave_q <= (nxt == match_i[0]);
                else if (nxt == match_i[0])    wave_q <= ~wave_q;
            end
        end
    end

    assign count_o = count_q;
    assign wave_o  = wave_q;

    // R11: count only moves on a step or a reload
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && state_q != ST_LOAD) |=> $stable(count_q));

    // R4: upward interval count wraps from the limit to zero
    p_wrap_intv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ovf_mode_i && !down_i && count_q == limit_i) |=> (count_q == '0));

    // R5: upward overflow count wraps from all ones to zero
    p_wrap_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ovf_mode_i && !down_i && count_q == '1) |=> (count_q == '0));

    // R7: without a compare-0 landing or a wrap, the waveform keeps its level
    p_wave_m0_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOAD && wave_en_i && !wrap && nxt != match_i[0])
        |=> ($stable(wave_q) || !wave_en_i));

endmodule

// File: rtl/pit_irq.sv
module pit_irq
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             evt_i,
    input  logic [NSTAT-1:0] ien_i,
    input  logic             clr_i,
    output logic [NSTAT-1:0] stat_o,
    output logic             irq_o
);
    logic [NSTAT-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (clr_i ? '0 : stat_q) | evt_i;
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & ien_i);

    // R10: a read with no simultaneous event empties the status
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (stat_q == '0));

    // R10: pending bits stay until read
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/pwm_interval_timer.sv
module pwm_interval_timer
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [2:0]    addr_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] rdata_o,
    output logic          wave_o,
    output logic          irq_o
);
    ctrl_t                       ctrl_q;
    logic [CW-1:0]               limit_q;
    logic [NMATCH-1:0][CW-1:0]   match_q;
    logic [NSTAT-1:0]            ien_q;
    logic [NSTAT-1:0]            stat;
    logic [CW-1:0]               count;
    logic                        wr_ctrl, rd_stat, run, load, step;
    evt_t                        evt;

    assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
    assign rd_stat = rd_en_i && (addr_i == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            limit_q <= '0;
            match_q <= '0;
            ien_q   <= '0;
        end else begin
            ctrl_q.restart <= 1'b0;
            if (wr_en_i) begin
                case (addr_i)
                    A_CTRL:   ctrl_q     <= ctrl_t'(wdata_i[15:0]);
                    A_LIMIT:  limit_q    <= wdata_i;
                    A_MATCH0: match_q[0] <= wdata_i;
                    A_MATCH1: match_q[1] <= wdata_i;
                    A_MATCH2: match_q[2] <= wdata_i;
                    A_IEN:    ien_q      <= wdata_i[NSTAT-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = CW'(ctrl_q);
            A_LIMIT:  rdata_o = limit_q;
            A_MATCH0: rdata_o = match_q[0];
            A_MATCH1: rdata_o = match_q[1];
            A_MATCH2: rdata_o = match_q[2];
            A_IEN:    rdata_o = CW'(ien_q);
            A_STAT:   rdata_o = CW'(stat);
            default:  rdata_o = count;
        endcase
    end

    pit_prescaler #(.SELW(PSEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .tick_i  (tick_i && run),
        .en_i    (ctrl_q.pre_en),
        .sel_i   (ctrl_q.pre_sel),
        .step_o  (step)
    );

    pit_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_i     (ctrl_q.halt),
        .restart_i  (wr_ctrl && wdata_i[1]),
        .down_i     (ctrl_q.down),
        .ovf_mode_i (ctrl_q.ovf_mode),
        .match_en_i (ctrl_q.match_en),
        .wave_en_i  (ctrl_q.wave_en),
        .limit_i    (limit_q),
        .match_i    (match_q),
        .step_i     (step),
        .run_o      (run),
        .load_o     (load),
        .count_o    (count),
        .wave_o     (wave_o),
        .evt_o      (evt)
    );

    pit_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .ien_i  (ien_q),
        .clr_i  (rd_stat),
        .stat_o (stat),
        .irq_o  (irq_o)
    );

endmodule

// File: tb/pwm_interval_timer_tb_top.sv
module pwm_interval_timer_tb_top;
    localparam int CLK_P = 10;
    localparam int CW    = 16;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick  = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr  = 3'd0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          wave, irq;

    typedef struct {
        logic [CW-1:0] exp;
        string         tag;
    } item_t;

    item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pwm_interval_timer #(.CW(CW)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .wave_o  (wave),
        .irq_o   (irq)
    );

    // monitor: compares read data against the scoreboard a quarter period after the drive edge
    always @(negedge clk) begin
        item_t it;
        #(CLK_P/4);
        if (rd_en) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: got %h expected none", rdata);
            end else begin
                it = sb_q.pop_front();
                if (rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [CW-1:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        @(negedge clk); rd_en = 1'b1; addr = a;
        sb_q.push_back(it);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pin(input string which, input logic e, input string tag);
        logic a;
        @(negedge clk);
        #(CLK_P/4);
        a = (which == "wave") ? wave : irq;
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: %s got %b expected %b", tag, which, a, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(3'd0, 16'h0001, "R1 ctrl reset");
        rd(3'd7, 16'h0000, "R1 count reset");
        rd(3'd6, 16'h0000, "R1 status reset");
        pin("wave", 1'b0, "R1");
        pin("irq",  1'b0, "R1");

        ticks(5);
        rd(3'd7, 16'h0000, "R8 halted ignores ticks");

        wr(3'd1, 16'd9);
        wr(3'd2, 16'd5);
        wr(3'd3, 16'd2);
        wr(3'd4, 16'd7);
        wr(3'd5, 16'h0001);
        wr(3'd0, 16'h0030);              // run, up, interval, compares, waveform

        ticks(3);
        rd(3'd7, 16'd3, "R2 bypass / R3 up");
        repeat (6) @(negedge clk);
        rd(3'd7, 16'd3, "R11 hold without ticks");
        pin("wave", 1'b0, "R7 compare1 leaves wave");

        ticks(2);
        rd(3'd7, 16'd5, "R3 up count");
        pin("wave", 1'b1, "R7 compare0 toggles");
        pin("irq",  1'b0, "R10 compare causes masked");
        rd(3'd6, 16'h000C, "R6 compare0/1 status");
        rd(3'd6, 16'h0000, "R10 read clears");

        ticks(5);
        pin("irq",  1'b1, "R10 interval enabled");
        pin("wave", 1'b0, "R7 wrap returns low");
        rd(3'd7, 16'd0, "R4 up wrap at limit");
        rd(3'd6, 16'h0011, "R4 interval + R6 compare2");
        pin("irq",  1'b0, "R10 irq drops after read");

        wr(3'd0, 16'h0036);              // restart, down
        rd(3'd7, 16'd9, "R9 down restart at limit");
        rd(3'd0, 16'h0034, "R9 restart self-clears");
        ticks(3);
        rd(3'd7, 16'd6, "R3 down count");
        ticks(7);
        rd(3'd7, 16'd9, "R4 down wrap to limit");
        rd(3'd6, 16'h001D, "R4 R6 down status");
        pin("wave", 1'b0, "R7 down wrap low");

        wr(3'd5, 16'h0003);
        wr(3'd0, 16'h000E);              // restart, down, overflow mode
        rd(3'd7, 16'hFFFF, "R9 overflow down restart");
        wr(3'd0, 16'h0008);              // up, overflow mode
        ticks(1);
        rd(3'd7, 16'h0000, "R5 up wrap from all ones");
        pin("irq",  1'b1, "R5 overflow irq");
        rd(3'd6, 16'h0002, "R5 overflow status");
        pin("wave", 1'b0, "R7 wave disabled");
        wr(3'd0, 16'h000C);              // down, overflow mode
        ticks(1);
        rd(3'd7, 16'hFFFF, "R5 down wrap to all ones");
        rd(3'd6, 16'h0002, "R5 down overflow status");

        wr(3'd0, 16'h0142);              // restart, prescaler on, N=1
        ticks(7);
        rd(3'd7, 16'd1, "R2 divide by 4 partial");
        ticks(1);
        rd(3'd7, 16'd2, "R2 divide by 4");

        wr(3'd0, 16'h0141);              // halt, others kept
        rd(3'd0, 16'h0141, "R8 other bits kept");
        ticks(8);
        rd(3'd7, 16'd2, "R8 halted count");

        wr(3'd0, 16'h0042);              // restart, prescaler on, N=0
        ticks(5);
        rd(3'd7, 16'd2, "R2 divide by 2");

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule